// File: doc/BRIEF.md
# I2C Master Write Engine

This block is a two-wire bus master that only performs write transfers. Software programs a 7-bit target address, writes the SCL low and high durations, and then writes data bytes one at a time into a single-byte holding register. The first write to the holding register while the bus is idle starts a transfer. The engine sends a start condition, then the address byte with a direction bit of 0, then each queued data byte. It checks the target's acknowledge after every byte.

Each acknowledged byte frees the holding register for the next byte. When an acknowledge arrives and no new byte is waiting, the engine finishes with a stop condition by itself. A missing acknowledge also ends the transfer with a stop. The open-drain lines appear as pull-low enables. Three status flags, each with its own interrupt enable, feed a single interrupt output.

Top module: `i2c_wr_master`

## Requirements
- R1: After reset, both line enables are 0 (lines released), `irq` is 0, and the status word (register 3 read: bit0 transfer-complete, bit1 transmit-ready, bit2 not-acknowledged) reads 3'b011.
- R2: A write to register 2 (holding register, bits [7:0]) while idle starts a transfer. SDA is pulled low while SCL is released (start condition), and transfer-complete reads 0 until the transfer has ended.
- R3: The first byte on the bus is the address from register 0 bits [6:0], shifted left, with a direction bit of 0 in the LSB. Every byte is sent MSB first.
- R4: On the 9th SCL pulse of each byte the master releases SDA. An acknowledge (SDA low) moves the waiting byte into the shifter and sets transmit-ready, which stays 1 until register 2 is written again. Queued bytes follow without another start.
- R5: If a byte is acknowledged while transmit-ready is 1, the master sends a stop condition (SDA rises while SCL is released). Transfer-complete then reads 1 and both lines are released.
- R6: If SDA is high on the 9th pulse, the not-acknowledged flag is set and a stop is sent. Transfer-complete is set, any byte still waiting is discarded (transmit-ready reads 1), and no new transfer starts.
- R7: Reading register 3 clears the not-acknowledged flag.
- R8: SCL is held low for the cycles set in register 1 bits [7:0] and released for the cycles set in bits [15:8]. Values below 2 act as 2.
- R9: SDA changes only while SCL stays low, except for the start and stop conditions. SDA never changes in the same cycle as SCL.
- R10: `irq` is the OR of each status flag ANDed with its enable, written through register 3 bits [2:0] in the same bit order as the status word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe (a read of register 3 clears not-acknowledged) |
| regAddr | input | 2 | Register select: 0 address, 1 clock periods, 2 holding, 3 status/enable |
| regWdata | input | 16 | Register write data |
| regRdata | output | 16 | Register read data for `regAddr` |
| sdaIn | input | 1 | Sampled level of the SDA line |
| sclOe | output | 1 | 1 pulls SCL low |
| sdaOe | output | 1 | 1 pulls SDA low |
| irq | output | 1 | Active-high interrupt |

## Verification
The bench attaches a target model that decodes the bus and acknowledges or refuses chosen bytes. It goes after these corner cases:

- **Last byte:** the stop must follow it. A design that missed this would stall with SCL low or clock out a stale byte.
- **Refused address:** a design that got this wrong would go on sending data.
- **Refused data byte with a byte already queued:** a design that got this wrong would restart the bus with the discarded byte.

The bench also measures every SCL low and high pulse, including periods programmed below the minimum. It watches for any SDA edge that coincides with an SCL edge, which would show up as a false start or stop. It checks that the interrupt follows the enables and that a status read clears not-acknowledged, which a sticky flag would fail.

// File: rtl/i2cw_pkg.sv
package i2cw_pkg;
  localparam int REG_AW = 2;
  localparam logic [REG_AW-1:0] REG_TADDR = 2'd0;
  localparam logic [REG_AW-1:0] REG_CLOCK = 2'd1;
  localparam logic [REG_AW-1:0] REG_HOLD  = 2'd2;
  localparam logic [REG_AW-1:0] REG_STAT  = 2'd3;

  typedef enum logic [2:0] {
    PH_IDLE, PH_START, PH_BITLO, PH_BITHI, PH_STOPLO, PH_STOPHI, PH_STOPREL
  } phase_e;

  typedef struct packed {
    logic loadAddr;
    logic loadHold;
    logic shiftNext;
    logic setNack;
    logic setComp;
    logic clrComp;
  } ctlStrobe_t;
endpackage

// File: rtl/i2cw_ctrl.sv
module i2cw_ctrl
  import i2cw_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] lowPer,
  input  logic [CNT_W-1:0] highPer,
  input  logic             txRdy,
  input  logic             curBit,
  input  logic             sdaIn,
  output ctlStrobe_t       stb,
  output logic             sclOe,
  output logic             sdaOe,
  output logic             busy
);
  localparam logic [CNT_W-1:0] MIN_PER = CNT_W'(2);

  phase_e     phase, phaseNxt;
  logic [CNT_W-1:0] cnt, lowEff, highEff, phaseLen;
  logic [3:0] bitIdx;
  logic       sdaQ;
  logic       phaseEnd, lowPhase;

  assign lowEff   = (lowPer  < MIN_PER) ? MIN_PER : lowPer;
  assign highEff  = (highPer < MIN_PER) ? MIN_PER : highPer;
  assign lowPhase = (phase == PH_BITLO) || (phase == PH_STOPLO);
  assign phaseLen = lowPhase ? lowEff : highEff;
  assign phaseEnd = (cnt == phaseLen - CNT_W'(1));

  always_comb begin
    phaseNxt = phase;
    stb      = '0;
    unique case (phase)
      PH_IDLE: if (!txRdy) begin
        phaseNxt     = PH_START;
        stb.loadAddr = 1'b1;
        stb.clrComp  = 1'b1;
      end
      PH_START:  if (phaseEnd) phaseNxt = PH_BITLO;
      PH_BITLO:  if (phaseEnd) phaseNxt = PH_BITHI;
      PH_BITHI:  if (phaseEnd) begin
        if (bitIdx != 4'd8) begin
          stb.shiftNext = 1'b1;
          phaseNxt      = PH_BITLO;
        end else if (sdaIn) begin
          stb.setNack = 1'b1;
          phaseNxt    = PH_STOPLO;
        end else if (!txRdy) begin
          stb.loadHold = 1'b1;
          phaseNxt     = PH_BITLO;
        end else begin
          phaseNxt = PH_STOPLO;
        end
      end
      PH_STOPLO: if (phaseEnd) phaseNxt = PH_STOPHI;
      PH_STOPHI: if (phaseEnd) phaseNxt = PH_STOPREL;
      PH_STOPREL: if (phaseEnd) begin
        stb.setComp = 1'b1;
        phaseNxt    = PH_IDLE;
      end
      default: phaseNxt = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase  <= PH_IDLE;
      cnt    <= '0;
      bitIdx <= '0;
      sdaQ   <= 1'b0;
    end else begin
      phase <= phaseNxt;
      cnt   <= (phaseNxt != phase) ? '0 : cnt + CNT_W'(1);
      if (phase == PH_START || stb.loadHold) bitIdx <= '0;
      else if (stb.shiftNext)                bitIdx <= bitIdx + 4'd1;
      // SDA moves only on the first cycle of a low phase, or in start/stop
      unique case (phase)
        PH_IDLE:    sdaQ <= 1'b0;
        PH_START:   sdaQ <= 1'b1;
        PH_BITLO:   if (cnt == '0) sdaQ <= (bitIdx == 4'd8) ? 1'b0 : ~curBit;
        PH_STOPLO:  if (cnt == '0) sdaQ <= 1'b1;
        PH_STOPREL: sdaQ <= 1'b0;
        default:    sdaQ <= sdaQ;
      endcase
    end
  end

  assign sclOe = lowPhase;
  assign sdaOe = sdaQ;
  assign busy  = (phase != PH_IDLE);
endmodule

// File: rtl/i2cw_dpath.sv
module i2cw_dpath
  import i2cw_pkg::*;
#(
  parameter int CNT_W    = 8,
  parameter int DEF_LOW  = 10,
  parameter int DEF_HIGH = 10,
  localparam int REG_DW  = 2 * CNT_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [REG_DW-1:0] regWdata,
  output logic [REG_DW-1:0] regRdata,
  input  ctlStrobe_t        stb,
  output logic [CNT_W-1:0]  lowPer,
  output logic [CNT_W-1:0]  highPer,
  output logic              txRdy,
  output logic              txComp,
  output logic              nackFlag,
  output logic              curBit,
  output logic              irq
);
  logic [6:0] tgtAddr;
  logic [7:0] holdReg, shiftReg;
  logic [2:0] irqEn, statVec;
  logic       holdWr, statRd;

  assign holdWr  = regWrEn && (regAddr == REG_HOLD);
  assign statRd  = regRdEn && (regAddr == REG_STAT);
  assign statVec = {nackFlag, txRdy, txComp};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tgtAddr  <= '0;
      lowPer   <= CNT_W'(DEF_LOW);
      highPer  <= CNT_W'(DEF_HIGH);
      holdReg  <= '0;
      shiftReg <= '0;
      irqEn    <= '0;
      txRdy    <= 1'b1;
      txComp   <= 1'b1;
      nackFlag <= 1'b0;
    end else begin
      if (regWrEn) begin
        unique case (regAddr)
          REG_TADDR: tgtAddr <= regWdata[6:0];
          REG_CLOCK: {highPer, lowPer} <= regWdata;
          REG_HOLD:  holdReg <= regWdata[7:0];
          default:   irqEn <= regWdata[2:0];
        endcase
      end
      if (stb.loadAddr)       shiftReg <= {tgtAddr, 1'b0};
      else if (stb.loadHold)  shiftReg <= holdReg;
      else if (stb.shiftNext) shiftReg <= {shiftReg[6:0], 1'b0};
      // a software write wins over a same-cycle release
      if (stb.loadHold || stb.setNack) txRdy <= 1'b1;
      if (holdWr)                      txRdy <= 1'b0;
      if (statRd)      nackFlag <= 1'b0;
      if (stb.setNack) nackFlag <= 1'b1;
      if (stb.clrComp)      txComp <= 1'b0;
      else if (stb.setComp) txComp <= 1'b1;
    end
  end

  always_comb begin
    unique case (regAddr)
      REG_TADDR: regRdata = REG_DW'(tgtAddr);
      REG_CLOCK: regRdata = {highPer, lowPer};
      REG_HOLD:  regRdata = REG_DW'(holdReg);
      default:   regRdata = REG_DW'(statVec);
    endcase
  end

  assign curBit = shiftReg[7];
  assign irq    = |(statVec & irqEn);
endmodule

// File: rtl/i2c_wr_master.sv
module i2c_wr_master
  import i2cw_pkg::*;
#(
  parameter int CNT_W    = 8,
  parameter int DEF_LOW  = 10,
  parameter int DEF_HIGH = 10
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 regWrEn,
  input  logic                 regRdEn,
  input  logic [1:0]           regAddr,
  input  logic [2*CNT_W-1:0]   regWdata,
  output logic [2*CNT_W-1:0]   regRdata,
  input  logic                 sdaIn,
  output logic                 sclOe,
  output logic                 sdaOe,
  output logic                 irq
);
  ctlStrobe_t       stb;
  logic [CNT_W-1:0] lowPer, highPer;
  logic             txRdy, txComp, nackFlag, curBit, busy;

  i2cw_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .lowPer(lowPer), .highPer(highPer),
    .txRdy(txRdy), .curBit(curBit), .sdaIn(sdaIn), .stb(stb),
    .sclOe(sclOe), .sdaOe(sdaOe), .busy(busy)
  );

  i2cw_dpath #(.CNT_W(CNT_W), .DEF_LOW(DEF_LOW), .DEF_HIGH(DEF_HIGH)) u_dpath (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata),
    .stb(stb), .lowPer(lowPer), .highPer(highPer), .txRdy(txRdy),
    .txComp(txComp), .nackFlag(nackFlag), .curBit(curBit), .irq(irq)
  );
endmodule

// File: rtl/i2cw_checker.sv
module i2cw_checker (
  input logic clk,
  input logic rstN,
  input logic busy,
  input logic sclOe,
  input logic sdaOe,
  input logic txComp,
  input logic txRdy
);
  // R9
  sda_scl_apart_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaOe) |-> $stable(sclOe));

  // R2
  comp_low_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !txComp);

  // R4
  rdy_on_high_scl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(txRdy) |-> $past(!sclOe));

  // R5
  comp_bus_free_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(txComp) |-> (!sclOe && !sdaOe));

  // R5
  idle_released_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!sclOe && !sdaOe));
endmodule

bind i2c_wr_master i2cw_checker u_chk (
  .clk(clk), .rstN(rstN), .busy(busy), .sclOe(sclOe),
  .sdaOe(sdaOe), .txComp(txComp), .txRdy(txRdy)
);

// File: tb/test_i2c_wr_master.sv
`timescale 1ns/1ps
module test_i2c_wr_master;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0, regRdEn = 1'b0;
  logic [1:0]  regAddr = '0;
  logic [15:0] regWdata = '0, regRdata;
  logic        sdaIn, sclOe, sdaOe, irq;
  logic        ackDrv = 1'b0;
  int checks = 0, failures = 0;
  bit done = 0;

  always #2.5 clk = ~clk;
  assign sdaIn = ~(sdaOe | ackDrv);

  i2c_wr_master i_i2c_wr_master (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata),
    .sdaIn(sdaIn), .sclOe(sclOe), .sdaOe(sdaOe), .irq(irq)
  );

  // bus target model and line monitor
  logic [7:0] rx [0:15];
  int rxCount = 0, starts = 0, stops = 0, viol = 0, nackAt = -1;
  int rc = 0, lowRun = 0, highRun = 0;
  int lowMin = 999, lowMax = 0, highMin = 999, highMax = 0;
  logic [7:0] cur = '0;
  logic pScl = 1'b1, pSda = 1'b1;

  always @(negedge clk) begin
    logic scl, sda;
    scl = ~sclOe;
    sda = ~(sdaOe | ackDrv);
    if (rstN) begin
      if (scl != pScl && sda != pSda) viol++;
      if (scl && pScl && pSda && !sda) begin starts++; rc = 0; end
      if (scl && pScl && !pSda && sda) stops++;
      if (scl && !pScl) begin
        if (lowRun < lowMin) lowMin = lowRun;
        if (lowRun > lowMax) lowMax = lowRun;
        highRun = 0;
        rc++;
        if (rc <= 8) cur = {cur[6:0], sda};
        if (rc == 9 && rxCount < 16) begin rx[rxCount] = cur; rxCount++; end
      end
      if (!scl && pScl) begin
        if (rc > 0) begin
          if (highRun < highMin) highMin = highRun;
          if (highRun > highMax) highMax = highRun;
        end
        lowRun = 0;
        if (rc == 8) ackDrv = (rxCount != nackAt);
        if (rc == 9) begin ackDrv = 1'b0; rc = 0; end
      end
      if (scl) highRun++; else lowRun++;
    end
    pScl = scl;
    pSda = sda;
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic regWrite(logic [1:0] a, logic [15:0] d);
    @(negedge clk);
    regAddr = a; regWdata = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic regRead(logic [1:0] a, output logic [15:0] d);
    @(negedge clk);
    regAddr = a; regRdEn = 1'b1;
    #1 d = regRdata;
    @(negedge clk);
    regRdEn = 1'b0;
  endtask

  task automatic clearMon(int nAt);
    rxCount = 0; starts = 0; stops = 0; viol = 0; nackAt = nAt;
    lowMin = 999; lowMax = 0; highMin = 999; highMax = 0;
  endtask

  task automatic waitStops(int n, string req);
    int k = 0;
    while (stops < n && k < 20000) begin @(negedge clk); k++; end
    check({req, " stop seen"}, (stops >= n), 1);
    repeat (20) @(negedge clk);
  endtask

  task automatic waitRdy(string req);
    logic [15:0] s = '0;
    int k = 0;
    do begin regRead(2'd3, s); k++; end while (!s[1] && k < 2000);
    check({req, " txRdy set after ack"}, s[1], 1);
  endtask

  task automatic t_reset();
    logic [15:0] s;
    check("R1 sclOe", sclOe, 0);
    check("R1 sdaOe", sdaOe, 0);
    check("R1 irq", irq, 0);
    regRead(2'd3, s);
    check("R1 status", s, 16'h0003);
  endtask

  task automatic t_single();
    logic [15:0] s;
    clearMon(-1);
    regWrite(2'd0, 16'h005A);
    regWrite(2'd1, 16'h0304);
    regWrite(2'd2, 16'h00C3);
    repeat (3) @(negedge clk);
    regRead(2'd3, s);
    check("R2 status busy", s, 16'h0000);
    check("R2 start seen", starts, 1);
    waitStops(1, "R5");
    check("R3 address byte", rx[0], 8'hB4);
    check("R4 data byte", rx[1], 8'hC3);
    check("R5 byte count", rxCount, 2);
    regRead(2'd3, s);
    check("R5 status done", s, 16'h0003);
    check("R5 lines free", {sclOe, sdaOe}, 2'b00);
    check("R8 low min", lowMin, 4);
    check("R8 low max", lowMax, 4);
    check("R8 high min", highMin, 3);
    check("R8 high max", highMax, 3);
    check("R9 coincident edges", viol, 0);
  endtask

  task automatic t_multi();
    logic [7:0] d [0:2];
    logic [15:0] s;
    d[0] = 8'hA5; d[1] = 8'h0F; d[2] = 8'hF0;
    clearMon(-1);
    regWrite(2'd0, 16'h0013);
    regWrite(2'd2, 16'(d[0]));
    for (int i = 1; i < 3; i++) begin
      waitRdy("R4");
      repeat (5) @(negedge clk);
      regRead(2'd3, s);
      check("R4 txRdy held", s[1], 1);
      regWrite(2'd2, 16'(d[i]));
      regRead(2'd3, s);
      check("R4 txRdy cleared by write", s[1], 0);
    end
    waitStops(1, "R5");
    check("R3 address byte", rx[0], 8'h26);
    for (int i = 0; i < 3; i++) check("R4 queued byte", rx[i+1], d[i]);
    check("R4 byte count", rxCount, 4);
    check("R4 single start", starts, 1);
    check("R5 single stop", stops, 1);
    check("R9 coincident edges", viol, 0);
  endtask

  task automatic t_nackAddr();
    logic [15:0] s;
    clearMon(0);
    regWrite(2'd0, 16'h0055);
    regWrite(2'd2, 16'h0099);
    waitStops(1, "R6");
    check("R6 bytes before stop", rxCount, 1);
    check("R6 stop count", stops, 1);
    regWrite(2'd3, 16'h0004);
    check("R10 irq on nack", irq, 1);
    regRead(2'd3, s);
    check("R6 status nack", s, 16'h0007);
    @(negedge clk);
    check("R7 irq drops after read", irq, 0);
    regRead(2'd3, s);
    check("R7 nack cleared", s, 16'h0003);
    regWrite(2'd3, 16'h0002);
    check("R10 irq on txRdy", irq, 1);
    regWrite(2'd3, 16'h0000);
    check("R10 irq masked", irq, 0);
  endtask

  task automatic t_nackData();
    logic [15:0] s;
    clearMon(1);
    regWrite(2'd0, 16'h002C);
    regWrite(2'd2, 16'h0081);
    waitRdy("R6");
    regWrite(2'd2, 16'h007E);
    waitStops(1, "R6");
    repeat (200) @(negedge clk);
    check("R6 address byte", rx[0], 8'h58);
    check("R6 refused byte", rx[1], 8'h81);
    check("R6 byte count", rxCount, 2);
    check("R6 no restart", starts, 1);
    regRead(2'd3, s);
    check("R6 status nack, pending dropped", s, 16'h0007);
  endtask

  task automatic t_clamp();
    clearMon(-1);
    regWrite(2'd1, 16'h0001);
    regWrite(2'd2, 16'h003C);
    waitStops(1, "R8");
    check("R8 clamped data", rx[1], 8'h3C);
    check("R8 clamped low", lowMin, 2);
    check("R8 clamped low max", lowMax, 2);
    check("R8 clamped high", highMin, 2);
    check("R8 clamped high max", highMax, 2);
    check("R9 coincident edges", viol, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_single();
    t_multi();
    t_nackAddr();
    t_nackData();
    t_clamp();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #(5ns * 150000);
    if (!done) begin
      done = 1;
      checks++; failures++;
      $display("FAIL watchdog actual=expired expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule